// File: doc/BRIEF.md
# Posted Column Command Latency Scheduler

This block sits behind the command decoder of a double-data-rate memory device and handles posted column commands. A READ or WRITE arriving on the command strobe is held for a programmed additive latency and then issued to the internal column logic. The block also works out when the data phase of each command falls. For a read it raises a one-cycle data-valid strobe at the read latency, which is the additive latency plus the CAS latency. For a write it raises a one-cycle capture strobe at the write latency, which is one clock less than the read latency.

A column command may arrive before the activate-to-column minimum has run out. It is accepted as long as the cycles already elapsed since the activate, plus the additive latency, reach that minimum. The block drops a command and pulses an error flag if the command is early, if the latency field holds its reserved code, or if the CAS latency setting is below the supported minimum.

The latency settings are copied into the active configuration only on a cycle with no command in flight and none presented. Because of this, commands on consecutive cycles always leave in arrival order.

Top module: `posted_cmd_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `iss_vld`, `rd_valid`, `wr_capture` and `err` are low.
- R2: For additive-latency codes 0 to 6, a command accepted at clock edge k drives `iss_vld` high for the single cycle after edge k+AL. `iss_wr` and `iss_col` carry the command's flag and column unchanged.
- R3: An accepted READ drives `rd_valid` high for the single cycle after edge k+AL+CL.
- R4: An accepted WRITE drives `wr_capture` high for the single cycle after edge k+AL+CL-1.
- R5: The additive-latency code 7 is reserved. A command seen under it raises `err` for the cycle after edge k and produces no issue and no strobe.
- R6: A CAS latency setting below 2 makes every command raise `err` for one cycle and be dropped.
- R7: A command is accepted only when `act_cnt` + AL is at least the parameter `TRCD_MIN` (default 6). Otherwise it raises `err` for one cycle and is dropped.
- R8: Commands on consecutive cycles are each issued after their own delay, in arrival order, with nothing lost.
- R9: A change on `al_code` or `cl_set` takes effect only at an edge where no command is in flight and `cmd_vld` is low. Until then, commands keep the latencies already in force.
- R10: The read strobe of one command and the write strobe of another may fall in the same cycle, and both are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Column command present this cycle |
| cmd_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | COL_W | Column address |
| al_code | input | 3 | Additive latency code; 0..6 clocks, 7 reserved |
| cl_set | input | CL_W | CAS latency in clocks |
| act_cnt | input | ACT_W | Saturating cycles elapsed since the bank activate |
| iss_vld | output | 1 | Internal column command issue |
| iss_wr | output | 1 | Flag of the issued command |
| iss_col | output | COL_W | Column of the issued command |
| rd_valid | output | 1 | Read data valid strobe |
| wr_capture | output | 1 | Write data capture strobe |
| err | output | 1 | Command rejected |

## Verification
The collision that matters is a READ followed on the next cycle by a WRITE. The write latency is one clock shorter, so the write's capture strobe lands in the same cycle as the read's valid strobe, while an internal issue from a later command can also fall there. A burst of alternating commands on consecutive cycles provokes this. Every output is compared each cycle against a timeline that the bench builds from the latency arithmetic alone, so a strobe that goes missing or moves by one cycle shows up as a miscompare in that cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Outcome of the admission check for one presented command.
  typedef enum logic [1:0] {
    ADM_OK    = 2'd0,
    ADM_RSVAL = 2'd1,
    ADM_BADCL = 2'd2,
    ADM_EARLY = 2'd3
  } adm_e;

  localparam int AL_FIELD_W = 3;
  localparam int AL_LIMIT   = 6;
endpackage

// File: rtl/pcs_delay_line.sv
// Fixed-length delay line that takes a write at a chosen tap. An entry that
// enters at tap t comes out of the output register at the t-th edge after
// it is written. The MSB of each word marks it as valid.
module pcs_delay_line #(
  parameter int DEPTH = 6,
  parameter int W     = 1,
  parameter int TAP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic [TAP_W-1:0] in_tap,
  input  logic [W-1:0]     in_data,
  output logic [W-1:0]     out_data,
  output logic             busy
);
  logic [W-1:0] slot_q [DEPTH];
  logic [W-1:0] chain  [DEPTH+1];
  logic [DEPTH:0] chain_msb;

  assign chain[DEPTH]     = '0;
  assign chain_msb[DEPTH] = 1'b0;
  for (genvar i = 0; i < DEPTH; i++) begin : g_chain
    assign chain[i]     = slot_q[i];
    assign chain_msb[i] = slot_q[i][W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (in_en && in_tap == TAP_W'(i + 1)) slot_q[i] <= in_data;
        else                                  slot_q[i] <= chain[i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         out_data <= '0;
    else if (in_en && in_tap == '0)  out_data <= in_data;
    else                             out_data <= chain[0];
  end

  assign busy = |chain_msb[DEPTH-1:0];

  // R2
  tap_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_en |-> (int'(in_tap) <= DEPTH));

  // R8
  slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    (in_en && int'(in_tap) <= DEPTH) |-> !chain_msb[in_tap]);
endmodule

// File: rtl/pcs_admit.sv
// Holds the active latency configuration and decides whether each presented
// command may enter the delay lines.
module pcs_admit #(
  parameter int CL_W     = 3,
  parameter int ACT_W    = 4,
  parameter int CL_MIN   = 2,
  parameter int TRCD_MIN = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cmd_vld,
  input  logic [pcs_pkg::AL_FIELD_W-1:0]  al_code,
  input  logic [CL_W-1:0]                 cl_set,
  input  logic [ACT_W-1:0]                act_cnt,
  input  logic                            busy,
  output logic                            acc,
  output logic [pcs_pkg::AL_FIELD_W-1:0]  al_q,
  output logic [CL_W-1:0]                 cl_q,
  output logic                            err_q
);
  import pcs_pkg::*;

  localparam int SUM_W = ACT_W + 1;

  adm_e        cause;
  logic [SUM_W-1:0] ready_at;

  assign ready_at = {1'b0, act_cnt} + SUM_W'(al_q);

  always_comb begin
    if (int'(al_q) > AL_LIMIT)              cause = ADM_RSVAL;
    else if (int'(cl_q) < CL_MIN)           cause = ADM_BADCL;
    else if (int'(ready_at) < TRCD_MIN)     cause = ADM_EARLY;
    else                                    cause = ADM_OK;
  end

  assign acc = cmd_vld && (cause == ADM_OK);

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q <= '0;
      cl_q <= CL_W'(CL_MIN);
    end else if (!busy && !cmd_vld) begin
      al_q <= al_code;
      cl_q <= cl_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= cmd_vld && (cause != ADM_OK);
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy || cmd_vld) |=> ($stable(al_q) && $stable(cl_q)));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(cmd_vld));
endmodule

// File: rtl/posted_cmd_sched.sv
module posted_cmd_sched #(
  parameter int COL_W    = 10,
  parameter int CL_W     = 3,
  parameter int ACT_W    = 4,
  parameter int CL_MIN   = 2,
  parameter int TRCD_MIN = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_vld,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       al_code,
  input  logic [CL_W-1:0]  cl_set,
  input  logic [ACT_W-1:0] act_cnt,
  output logic             iss_vld,
  output logic             iss_wr,
  output logic [COL_W-1:0] iss_col,
  output logic             rd_valid,
  output logic             wr_capture,
  output logic             err
);
  import pcs_pkg::*;

  localparam int CL_MAX   = (1 << CL_W) - 1;
  localparam int CMD_DEP  = AL_LIMIT;
  localparam int CTAP_W   = $clog2(CMD_DEP + 1);
  localparam int STB_DEP  = AL_LIMIT + CL_MAX;
  localparam int STAP_W   = $clog2(STB_DEP + 1);
  localparam int CMD_W    = COL_W + 2;

  logic                   acc;
  logic [AL_FIELD_W-1:0]  al_q;
  logic [CL_W-1:0]        cl_q;
  logic                   busy_c, busy_r, busy_w, busy;
  logic [STAP_W-1:0]      rl_tap, wl_tap;
  logic [CMD_W-1:0]       cmd_out;
  logic                   rd_out, wr_out;

  assign busy   = busy_c | busy_r | busy_w;
  assign rl_tap = STAP_W'(al_q) + STAP_W'(cl_q);
  assign wl_tap = rl_tap - STAP_W'(1);

  pcs_admit #(
    .CL_W(CL_W), .ACT_W(ACT_W), .CL_MIN(CL_MIN), .TRCD_MIN(TRCD_MIN)
  ) admit_i (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .al_code(al_code),
    .cl_set(cl_set), .act_cnt(act_cnt), .busy(busy), .acc(acc),
    .al_q(al_q), .cl_q(cl_q), .err_q(err)
  );

  pcs_delay_line #(.DEPTH(CMD_DEP), .W(CMD_W), .TAP_W(CTAP_W)) cmd_line_i (
    .clk(clk), .rst(rst), .in_en(acc), .in_tap(CTAP_W'(al_q)),
    .in_data({1'b1, cmd_wr, cmd_col}), .out_data(cmd_out), .busy(busy_c)
  );

  pcs_delay_line #(.DEPTH(STB_DEP), .W(1), .TAP_W(STAP_W)) rd_line_i (
    .clk(clk), .rst(rst), .in_en(acc && !cmd_wr), .in_tap(rl_tap),
    .in_data(1'b1), .out_data(rd_out), .busy(busy_r)
  );

  pcs_delay_line #(.DEPTH(STB_DEP), .W(1), .TAP_W(STAP_W)) wr_line_i (
    .clk(clk), .rst(rst), .in_en(acc && cmd_wr), .in_tap(wl_tap),
    .in_data(1'b1), .out_data(wr_out), .busy(busy_w)
  );

  assign iss_vld    = cmd_out[CMD_W-1];
  assign iss_wr     = cmd_out[CMD_W-2];
  assign iss_col    = cmd_out[COL_W-1:0];
  assign rd_valid   = rd_out;
  assign wr_capture = wr_out;

  // R2
  iss_align_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && al_q == '0) |-> $past(acc));

  // R5
  err_no_acc_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !$past(acc));
endmodule

// File: tb/posted_cmd_sched_tb_top.sv
`timescale 1ns/1ps
module posted_cmd_sched_tb_top;
  localparam int TRCD = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_vld = 1'b0, cmd_wr = 1'b0;
  logic [9:0] cmd_col = '0;
  logic [2:0] al_code = '0, cl_set = 3'd2;
  logic [3:0] act_cnt = 4'd15;
  logic       iss_vld, iss_wr, rd_valid, wr_capture, err;
  logic [9:0] iss_col;

  always #10 clk = ~clk;

  posted_cmd_sched dut_i (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_col(cmd_col), .al_code(al_code), .cl_set(cl_set),
    .act_cnt(act_cnt), .iss_vld(iss_vld), .iss_wr(iss_wr),
    .iss_col(iss_col), .rd_valid(rd_valid), .wr_capture(wr_capture),
    .err(err)
  );

  int vectors = 0, miscompares = 0, ncyc = 0, last_ev = -1;
  int m_al = 0, m_cl = 2;
  string cur_req = "R1";
  logic       e_iss [64];
  logic       e_wr  [64];
  logic [9:0] e_col [64];
  logic       e_rd  [64];
  logic       e_wc  [64];
  logic       e_err [64];

  task automatic report(string fld, int a, int e);
    $display("FAIL %s %s cycle %0d actual %0h expected %0h", cur_req, fld, ncyc, a, e);
  endtask

  task automatic check_now();
    int i = ncyc % 64;
    bit bad = 0;
    vectors++;
    if (iss_vld !== e_iss[i]) begin bad = 1; report("iss_vld", int'(iss_vld), int'(e_iss[i])); end
    if (e_iss[i] && iss_wr !== e_wr[i]) begin bad = 1; report("iss_wr", int'(iss_wr), int'(e_wr[i])); end
    if (e_iss[i] && iss_col !== e_col[i]) begin bad = 1; report("iss_col", int'(iss_col), int'(e_col[i])); end
    if (rd_valid !== e_rd[i]) begin bad = 1; report("rd_valid", int'(rd_valid), int'(e_rd[i])); end
    if (wr_capture !== e_wc[i]) begin bad = 1; report("wr_capture", int'(wr_capture), int'(e_wc[i])); end
    if (err !== e_err[i]) begin bad = 1; report("err", int'(err), int'(e_err[i])); end
    if (bad) miscompares++;
    e_iss[i] = 0; e_wr[i] = 0; e_col[i] = '0; e_rd[i] = 0; e_wc[i] = 0; e_err[i] = 0;
  endtask

  // Model the edge, then advance one cycle and compare at the falling edge.
  task automatic step();
    int e = ncyc + 1;
    if (cmd_vld) begin
      if (m_al == 7 || m_cl < 2 || int'(act_cnt) + m_al < TRCD) begin
        e_err[e % 64] = 1;
      end else begin
        e_iss[(e + m_al) % 64] = 1;
        e_wr[(e + m_al) % 64]  = cmd_wr;
        e_col[(e + m_al) % 64] = cmd_col;
        if (cmd_wr) e_wc[(e + m_al + m_cl - 1) % 64] = 1;
        else        e_rd[(e + m_al + m_cl) % 64] = 1;
        if (e + m_al + m_cl > last_ev) last_ev = e + m_al + m_cl;
      end
    end else if (last_ev < e) begin
      m_al = int'(al_code);
      m_cl = int'(cl_set);
    end
    @(posedge clk);
    ncyc++;
    @(negedge clk);
    check_now();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic send(bit wr, logic [9:0] col);
    cmd_vld = 1; cmd_wr = wr; cmd_col = col;
    step();
    cmd_vld = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      e_iss[i] = 0; e_wr[i] = 0; e_col[i] = '0; e_rd[i] = 0; e_wc[i] = 0; e_err[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    check_now();
    rst = 1'b0;
    check_now();
    // R1: first edge after reset also leaves outputs idle
    idle(2);

    // R2 R3 R4 R5 R6: sweep every latency code, CAS setting and direction
    for (int a = 0; a < 8; a++)
      for (int c = 0; c < 8; c++)
        for (int w = 0; w < 2; w++) begin
          if (a == 7) cur_req = "R5";
          else if (c < 2) cur_req = "R6";
          else cur_req = "R2 R3 R4";
          al_code = 3'(a); cl_set = 3'(c); act_cnt = 4'd15;
          idle(2);
          send(w[0], 10'((a * 16 + c * 2 + w) * 7));
          idle(16);
        end

    // R7: activate-to-column window around the minimum
    cur_req = "R7";
    al_code = 3'd3; cl_set = 3'd3;
    idle(2);
    for (int t = 0; t < 7; t++) begin
      act_cnt = 4'(t);
      send(1'b0, 10'(100 + t));
      idle(12);
    end
    al_code = 3'd6; act_cnt = 4'd0;
    idle(2);
    send(1'b1, 10'h2a5);
    idle(14);
    act_cnt = 4'd15;

    // R8 R10: back-to-back alternating burst, read and write strobes collide
    cur_req = "R8 R10";
    al_code = 3'd4; cl_set = 3'd3;
    idle(2);
    for (int b = 0; b < 6; b++) send(b[0], 10'(600 + b * 3));
    idle(16);
    al_code = 3'd0; cl_set = 3'd2;
    idle(2);
    for (int b = 0; b < 8; b++) send(b[0], 10'(700 + b));
    idle(12);

    // R9: setting change while commands are in flight is deferred
    cur_req = "R9";
    al_code = 3'd2; cl_set = 3'd2;
    idle(2);
    send(1'b0, 10'h111);
    al_code = 3'd5; cl_set = 3'd6;
    idle(1);
    send(1'b1, 10'h222);
    idle(20);
    send(1'b0, 10'h333);
    idle(16);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog run did not finish, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule